// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models the command side of a 16-bit parallel NOR flash as synthesizable logic. Once per system clock it samples a three-bit control vector (output enable, write enable, chip select), a word address and a data bus. A write strobe whose low data byte is a command moves the block between its read modes, or into a program-setup or erase-setup state. A read cycle returns array data, a buffered status byte or an identifier word, depending on the current mode.

The array is a parameterised window of erased words. Programming and erasing are not modelled: a setup state is only entered, and the next accepted write leaves it without touching the array. The block is intended to stand in for a flash part on a board-level bus model, so that a driver's command sequences can be exercised against it.

Top module: `flash_cmd_if`

## Requirements
- R1: After a synchronous active-high reset the block is in read-array mode with the status buffer at 0x00, and every array word reads as 0xFFFF.
- R2: The control vector uses bit 0 for output enable, bit 1 for write enable and bit 2 for chip select. A read cycle is the vector 3'b101 exactly. For every other vector `rdata_o` is 0x0000.
- R3: A write is accepted only when the vector is 3'b110 and write enable was low in the previous clock sample. A strobe held for several cycles is taken once, and a strobe that follows a cycle with write enable already high is not taken.
- R4: From any read mode, command 0x70 selects read-status, 0x90 selects read-identifier, and 0xFF, 0xD0, 0xB0 or any byte not listed in R4 or R5 selects read-array.
- R5: From any read mode, command 0x10 or 0x40 enters program setup and 0x20 enters erase setup. While in either setup state, reads return 0x0000.
- R6: In a setup state the next accepted write returns the block to read-status, whatever its data byte, and the array contents are unchanged.
- R7: Only bits 7:0 of `wdata_i` are decoded as a command. Bits 15:8 have no effect.
- R8: In read-identifier mode word address 0 returns 0x8893, word address 1 returns 0x0089, and all other addresses return 0x0000.
- R9: The status buffer copies the internal status byte (0x00 when idle) on a rising edge of output enable or of chip select. A read in read-status mode returns the buffer in bits 7:0 with bits 15:8 at zero.
- R10: In read-array mode, addresses at or above `DEPTH_WORDS` (default 200) lie outside the array and return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all control samples are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_i | input | 3 | Control vector: bit 0 output enable, bit 1 write enable, bit 2 chip select |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data; the low byte carries the command |
| rdata_o | output | 16 | Read data, valid during a read cycle and zero otherwise |

## Verification
The bench focuses on write-strobe edge detection. A held strobe, or a strobe that follows a cycle with both write enable and output enable high, must not be taken a second time. A design that levelled instead of edged would jump to the second command's mode. It writes commands with non-zero upper data bytes; decoding the full word would send such writes to read-array instead of read-status. It checks that leaving a setup state always lands in read-status, even when the byte would otherwise select read-array. A design that decoded that byte would return erased words where zeros are expected. It also probes the array boundary and identifier addresses above 1, where an incomplete address decode would return 0xFFFF or a code.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CTL_W   = 3;
    localparam int OE_BIT  = 0;
    localparam int WE_BIT  = 1;
    localparam int CS_BIT  = 2;
    localparam int WORD_W  = 16;
    localparam int CMD_W   = 8;

    localparam logic [CTL_W-1:0]  CTL_READ    = 3'b101;
    localparam logic [CTL_W-1:0]  CTL_WRITE   = 3'b110;
    localparam logic [CMD_W-1:0]  STATUS_IDLE = 8'h00;
    localparam logic [WORD_W-1:0] CODE_DEVICE = 16'h8893;
    localparam logic [WORD_W-1:0] CODE_MAKER  = 16'h0089;
    localparam logic [WORD_W-1:0] WORD_ERASED = {WORD_W{1'b1}};

    typedef enum logic [2:0] {
        MODE_ARRAY     = 3'd0,
        MODE_STATUS    = 3'd1,
        MODE_IDENT     = 3'd2,
        MODE_PGM_SETUP = 3'd3,
        MODE_ERS_SETUP = 3'd4
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic [CMD_W-1:0] stat_buf;
    } fsm_state_t;

    function automatic mode_e decode_cmd(input logic [CMD_W-1:0] cmd);
        mode_e m;
        case (cmd)
            8'h10, 8'h40: m = MODE_PGM_SETUP;
            8'h20:        m = MODE_ERS_SETUP;
            8'h70:        m = MODE_STATUS;
            8'h90:        m = MODE_IDENT;
            default:      m = MODE_ARRAY;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/flash_cmd_edge.sv
module flash_cmd_edge
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ctl_i,
    output logic             wr_take_o,
    output logic             stat_latch_o
);

    logic [CTL_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d       = ctl_i;
        wr_take_o    = (ctl_i == CTL_WRITE) && !prev_q[WE_BIT];
        stat_latch_o = (ctl_i[OE_BIT] && !prev_q[OE_BIT]) ||
                       (ctl_i[CS_BIT] && !prev_q[CS_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_take_i,
    input  logic             stat_latch_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [CMD_W-1:0] status_i,
    output mode_e            mode_o,
    output logic [CMD_W-1:0] stat_buf_o
);

    fsm_state_t st_d, st_q;
    logic       in_setup;

    always_comb begin
        st_d     = st_q;
        in_setup = (st_q.mode == MODE_PGM_SETUP) || (st_q.mode == MODE_ERS_SETUP);
        if (stat_latch_i) st_d.stat_buf = status_i;
        if (wr_take_i) begin
            if (in_setup) st_d.mode = MODE_STATUS;
            else          st_d.mode = decode_cmd(cmd_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode     <= MODE_ARRAY;
            st_q.stat_buf <= STATUS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign stat_buf_o = st_q.stat_buf;

endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DEPTH_WORDS = 200
) (
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  mode_e             mode_i,
    input  logic [CMD_W-1:0]  stat_buf_i,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int SPAN = 1 << ADDR_W;

    logic in_range;

    generate
        if (DEPTH_WORDS >= SPAN) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_window
            assign in_range = (32'(addr_i) < DEPTH_WORDS);
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (ctl_i == CTL_READ) begin
            case (mode_i)
                MODE_ARRAY:  if (in_range) rdata_o = WORD_ERASED;
                MODE_STATUS: rdata_o = {{(WORD_W-CMD_W){1'b0}}, stat_buf_i};
                MODE_IDENT: begin
                    if (addr_i == '0)                rdata_o = CODE_DEVICE;
                    else if (addr_i == ADDR_W'(1))   rdata_o = CODE_MAKER;
                end
                default: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DEPTH_WORDS = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o
);

    logic             wr_take;
    logic             stat_latch;
    mode_e            mode_q;
    logic [CMD_W-1:0] stat_buf;

    flash_cmd_edge u_edge (
        .clk          (clk),
        .rst          (rst),
        .ctl_i        (ctl_i),
        .wr_take_o    (wr_take),
        .stat_latch_o (stat_latch)
    );

    flash_cmd_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .wr_take_i    (wr_take),
        .stat_latch_i (stat_latch),
        .cmd_i        (wdata_i[CMD_W-1:0]),
        .status_i     (STATUS_IDLE),
        .mode_o       (mode_q),
        .stat_buf_o   (stat_buf)
    );

    flash_cmd_rdmux #(
        .ADDR_W      (ADDR_W),
        .DEPTH_WORDS (DEPTH_WORDS)
    ) u_rdmux (
        .ctl_i      (ctl_i),
        .addr_i     (addr_i),
        .mode_i     (mode_q),
        .stat_buf_i (stat_buf),
        .rdata_o    (rdata_o)
    );

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        ctl_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [15:0]       rdata_o,
    input mode_e             mode_q,
    input logic              wr_take
);

    logic primed_q;

    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctl_i != CTL_READ) |-> (rdata_o == 16'h0000));

    a_r3_single_take: assert property (@(posedge clk) disable iff (rst)
        (primed_q && ctl_i == CTL_WRITE && $past(ctl_i) == CTL_WRITE) |-> !wr_take);

    a_r4_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_take |=> $stable(mode_q));

    a_r5_setup_dark: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PGM_SETUP || mode_q == MODE_ERS_SETUP) |-> (rdata_o == 16'h0000));

    a_r6_setup_exit: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_PGM_SETUP || mode_q == MODE_ERS_SETUP) && wr_take)
        |=> (mode_q == MODE_STATUS));

    a_r8_ident_blank: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IDENT && ctl_i == CTL_READ && addr_i > ADDR_W'(1))
        |-> (rdata_o == 16'h0000));

endmodule

bind flash_cmd_if flash_cmd_if_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ctl_i   (ctl_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .mode_q  (mode_q),
    .wr_take (wr_take)
);

// File: tb/flash_cmd_if_tb_top.sv
module flash_cmd_if_tb_top;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 200;

    // bench-local mode codes
    localparam int M_ARR = 0, M_STS = 1, M_ID = 2, M_PGM = 3, M_ERS = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [2:0]        ctl;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       wdata;
    logic [15:0]       rdata;

    int  n_checks = 0;
    int  n_errors = 0;
    int  m_mode   = M_ARR;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_if #(.ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );

    function automatic int next_mode(input int m, input logic [7:0] b);
        if (m == M_PGM || m == M_ERS) return M_STS;
        if (b == 8'h10 || b == 8'h40) return M_PGM;
        if (b == 8'h20) return M_ERS;
        if (b == 8'h70) return M_STS;
        if (b == 8'h90) return M_ID;
        return M_ARR;
    endfunction

    function automatic logic [15:0] exp_read(input int m, input int a);
        case (m)
            M_ARR: return (a < DEPTH) ? 16'hFFFF : 16'h0000;
            M_ID:  return (a == 0) ? 16'h8893 : ((a == 1) ? 16'h0089 : 16'h0000);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: rdata=%h expected=%h (t=%0t)", req, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); ctl = 3'b000;
        @(negedge clk); ctl = 3'b110; wdata = d;
        @(negedge clk); ctl = 3'b000;
        m_mode = next_mode(m_mode, d[7:0]);
    endtask

    task automatic rd(input string req, input int a);
        @(negedge clk); ctl = 3'b101; addr = ADDR_W'(a);
        #1 check(req, rdata, exp_read(m_mode, a));
    endtask

    task automatic idle_probe(input string req, input logic [2:0] c);
        @(negedge clk); ctl = c; addr = ADDR_W'($urandom % 256);
        #1 check(req, rdata, 16'h0000);
    endtask

    initial begin
        logic [7:0] picks [10] = '{8'h10, 8'h40, 8'h20, 8'h70, 8'h90,
                                   8'hD0, 8'hB0, 8'hFF, 8'h55, 8'h00};
        logic [2:0] quiet [6]  = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b111};
        void'($urandom(32'd20240611));
        rst = 1'b1; ctl = 3'b000; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state is read-array, erased words
        rd("R1", 0);
        rd("R1", 57);
        // R2: non-read vectors give zero
        idle_probe("R2", 3'b000);
        idle_probe("R2", 3'b111);
        idle_probe("R2", 3'b001);
        idle_probe("R2", 3'b100);
        // R8 / R4: identifier mode
        wr(16'h0090);
        rd("R8", 0);
        rd("R8", 1);
        rd("R8", 5);
        rd("R8", 255);
        // R3: strobe after WE already high is not taken
        @(negedge clk); ctl = 3'b111;
        @(negedge clk); ctl = 3'b110; wdata = 16'h0070;
        @(negedge clk); ctl = 3'b000;
        rd("R3", 0);
        // R3: held strobe taken once (0xFF taken, 0x70 not)
        @(negedge clk); ctl = 3'b000;
        @(negedge clk); ctl = 3'b110; wdata = 16'h00FF;
        @(negedge clk); wdata = 16'h0070;
        @(negedge clk); ctl = 3'b000;
        m_mode = M_ARR;
        rd("R3", 3);
        // R7 / R9: upper byte ignored, status reads 0x0000
        wr(16'hAB70);
        rd("R7", 0);
        rd("R9", 9);
        // R5 / R6: program setup
        wr(16'h0040);
        rd("R5", 0);
        wr(16'h0012);
        rd("R6", 0);
        wr(16'h00FF);
        rd("R6", 0);
        rd("R6", 199);
        // R5 / R6: erase setup exits to status even on 0xD0
        wr(16'h0020);
        rd("R5", 2);
        wr(16'h00D0);
        rd("R6", 2);
        wr(16'h3410);
        rd("R5", 1);
        wr(16'h00B0);
        rd("R6", 1);
        wr(16'h00B0);
        rd("R4", 1);
        // R4: unlisted byte from identifier mode falls back to array
        wr(16'h0090);
        wr(16'h0055);
        rd("R4", 0);
        // R10: array window
        rd("R10", 199);
        rd("R10", 200);
        rd("R10", 255);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                logic [15:0] d;
                d = (($urandom % 4) == 0) ? 16'($urandom)
                                          : {8'($urandom), picks[$urandom % 10]};
                wr(d);
            end else if (op == 3) begin
                idle_probe("R2", quiet[$urandom % 6]);
            end else begin
                rd("R4", int'($urandom % 256));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, got=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule